// File: doc/BRIEF.md
# Flash Word-Program Write Controller

This block programs an on-chip flash array one 16-bit word at a time while software or a DMA channel feeds it single bytes. Software loads a start word address and an even byte count, then sets the start bit. The controller asserts a data request whenever its byte slot can take a byte, so a DMA channel can stream the block. The channel runs one byte per request, with an incrementing source and a fixed destination that is the data register. Each pair of bytes becomes one word, programmed over a fixed number of cycles. The word address then steps by one, so a block may cross a 512-word page boundary without help.

The word address is 14 bits wide. Bits [13:9] select the page and bits [8:0] select the word within it, and the address equals half of the unified byte address (byte 0x0BFE is word 0x05FF, page 2, word 511). While a word is being programmed the array cannot be read. Any CPU access, data or instruction fetch, is stalled with ready low and returns zero, and it sets a sticky violation flag. The array is modelled as `MEM_DEPTH` words that read as erased (0xFFFF) after reset.

The controller is a four-state machine:
- IDLE: no session is running.
- WAIT_LOW: waits for the first byte of a pair.
- WAIT_HIGH: waits for the second byte.
- PROGRAM: the program window is open.

Its transitions are:
- START: IDLE to WAIT_LOW.
- LOW_TAKEN: WAIT_LOW to WAIT_HIGH.
- PAIR_DONE: WAIT_HIGH to PROGRAM.
- NEXT_PAIR: PROGRAM to WAIT_LOW.
- SESSION_END: PROGRAM to IDLE.

Top module: `flash_word_writer`

## Requirements
- R1: After reset the start bit, busy, violation, word address, byte count and DMA request are all 0, CPU ready is 1, and every in-range word reads 0xFFFF.
- R2: Register select codes are 0 control, 1 word address (data bits [13:0]), 2 byte count (bit 0 forced to 0, so an odd count rounds down) and 3 write data (bits [7:0]). Address and count writes take effect one edge later, and only while no session is running.
- R3: Writing control with bit 0 set while idle and with a nonzero count sets the start bit (`ctl_write`) on the next edge. A start with a zero count, or during a session, has no effect.
- R4: `dma_req` is high exactly while a session waits for a byte (WAIT_LOW or WAIT_HIGH), and low while idle or programming.
- R5: Each accepted byte lowers the count by one. The first byte of a pair is the low half of the word and the second byte is the high half.
- R6: The edge that accepts the second byte of a pair raises busy, which then stays high for exactly `PROG_CYCLES` cycles.
- R7: The edge that ends the program window writes the word into the array and increments the word address by one, wrapping over 14 bits and crossing page boundaries (0x01FF to 0x0200).
- R8: If the count is zero when a program window ends, the start bit clears, and no request follows until the next start.
- R9: A CPU access while busy sees ready 0 and data 0, and it sets the violation flag. Otherwise ready is 1 and the word at `cpu_waddr` is returned in the same cycle.
- R10: A data-register write while busy is discarded and sets the violation flag. A data write while idle is discarded and leaves the flag unchanged.
- R11: The violation flag is sticky. A control write with bit 1 set clears it, but a violation in the same cycle takes precedence.
- R12: Words at address `MEM_DEPTH` and above read as 0xFFFF, and programs aimed there are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 address, 2 count, 3 data) |
| reg_wdata | input | ADDR_W | Register write value |
| ctl_write | output | 1 | Start bit: session running |
| ctl_busy | output | 1 | Word program in progress |
| ctl_viol | output | 1 | Sticky access-violation flag |
| cur_waddr | output | ADDR_W | Current word address |
| bytes_left | output | CNT_W | Remaining byte count |
| dma_req | output | 1 | Request for the next data byte |
| cpu_req | input | 1 | CPU flash access (data or fetch) |
| cpu_waddr | input | ADDR_W | CPU word address |
| cpu_ready | output | 1 | Access serviced this cycle |
| cpu_rdata | output | 16 | Word returned to the CPU |

## Verification
Register-side results (start bit, address, count, violation flag, request) are due one edge after the write or access that causes them. Busy rises one edge after the second byte of a pair, and the array contents and address change at the edge that closes the `PROG_CYCLES` window. CPU ready and read data respond within the same cycle as the request. The bench drives inputs just after each rising edge, so a behavioural model and the design both see stable inputs at the next edge. Every output is compared against the model at the falling edge, where all of these delays have already settled.

// File: rtl/fww_pkg.sv
package fww_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_PROGRAM
    } fww_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_DATA  = 2'd3;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int BYTE_W       = 8;
    localparam int WORD_W       = 2 * BYTE_W;
endpackage

// File: rtl/fww_fsm.sv
module fww_fsm
    import fww_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic byte_i,
    input  logic prog_done_i,
    input  logic count_zero_i,
    output logic active_o,
    output logic idle_o,
    output logic busy_o,
    output logic dma_req_o,
    output logic take_lo_o,
    output logic take_hi_o,
    output logic commit_o
);
    fww_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, LOW_TAKEN, PAIR_DONE, NEXT_PAIR, SESSION_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_WAIT_LOW;
            ST_WAIT_LOW:  if (byte_i)  state_d = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (byte_i)  state_d = ST_PROGRAM;
            ST_PROGRAM: begin
                if (prog_done_i)
                    state_d = count_zero_i ? ST_IDLE : ST_WAIT_LOW;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active_o  = 1'b0;
        idle_o    = 1'b0;
        busy_o    = 1'b0;
        dma_req_o = 1'b0;
        take_lo_o = 1'b0;
        take_hi_o = 1'b0;
        commit_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: idle_o = 1'b1;
            ST_WAIT_LOW: begin
                active_o  = 1'b1;
                dma_req_o = 1'b1;
                take_lo_o = byte_i;
            end
            ST_WAIT_HIGH: begin
                active_o  = 1'b1;
                dma_req_o = 1'b1;
                take_hi_o = byte_i;
            end
            ST_PROGRAM: begin
                active_o = 1'b1;
                busy_o   = 1'b1;
                commit_o = prog_done_i;
            end
            default: idle_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/fww_timer.sv
module fww_timer #(
    parameter int PROG_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int TMR_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(PROG_CYCLES - 1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (load_i)                     cnt_q <= LOAD_VAL;
        else if (run_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/fww_datapath.sv
module fww_datapath
    import fww_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              idle_i,
    input  logic              busy_i,
    input  logic              take_lo_i,
    input  logic              take_hi_i,
    input  logic              commit_i,
    input  logic              cpu_req_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [WORD_W-1:0] word_o,
    output logic              viol_o,
    output logic              count_zero_o
);
    logic [BYTE_W-1:0] lo_q;
    logic              viol_set, viol_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_o <= '0;
        else if (commit_i)
            addr_o <= addr_o + 1'b1;
        else if (idle_i && reg_we && reg_sel == SEL_ADDR)
            addr_o <= reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (take_lo_i || take_hi_i)
            count_o <= count_o - 1'b1;
        else if (idle_i && reg_we && reg_sel == SEL_COUNT)
            count_o <= {reg_wdata[CNT_W-1:1], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            word_o <= '0;
        end else begin
            if (take_lo_i) lo_q   <= reg_wdata[BYTE_W-1:0];
            if (take_hi_i) word_o <= {reg_wdata[BYTE_W-1:0], lo_q};
        end
    end

    assign viol_set = busy_i && ((reg_we && reg_sel == SEL_DATA) || cpu_req_i);
    assign viol_clr = reg_we && reg_sel == SEL_CTRL && reg_wdata[CTRL_CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        viol_o <= 1'b0;
        else if (viol_set) viol_o <= 1'b1;
        else if (viol_clr) viol_o <= 1'b0;
    end

    assign count_zero_o = (count_o == '0);
endmodule

// File: rtl/fww_array.sv
module fww_array
    import fww_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int MEM_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic              ready_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int IDX_W = $clog2(MEM_DEPTH);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(MEM_DEPTH);

    logic [WORD_W-1:0] mem [MEM_DEPTH];
    logic              w_in, r_in;

    assign w_in = {1'b0, waddr_i} < DEPTH_L;
    assign r_in = {1'b0, raddr_i} < DEPTH_L;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '1;
        end else if (we_i && w_in) begin
            mem[waddr_i[IDX_W-1:0]] <= wdata_i;
        end
    end

    always_comb begin
        ready_o = !busy_i;
        if (busy_i)    rdata_o = '0;
        else if (r_in) rdata_o = mem[raddr_i[IDX_W-1:0]];
        else           rdata_o = '1;
    end
endmodule

// File: rtl/flash_word_writer.sv
module flash_word_writer
    import fww_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int CNT_W       = 10,
    parameter int PROG_CYCLES = 6,
    parameter int MEM_DEPTH   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              ctl_write,
    output logic              ctl_busy,
    output logic              ctl_viol,
    output logic [ADDR_W-1:0] cur_waddr,
    output logic [CNT_W-1:0]  bytes_left,
    output logic              dma_req,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_waddr,
    output logic              cpu_ready,
    output logic [15:0]       cpu_rdata
);
    logic              idle, take_lo, take_hi, commit, prog_done, count_zero;
    logic              start, byte_wr, load_tmr;
    logic [WORD_W-1:0] word;

    assign byte_wr  = reg_we && reg_sel == SEL_DATA;
    assign start    = reg_we && reg_sel == SEL_CTRL && reg_wdata[CTRL_GO_BIT]
                      && idle && !count_zero;
    assign load_tmr = take_hi;

    fww_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .byte_i       (byte_wr),
        .prog_done_i  (prog_done),
        .count_zero_i (count_zero),
        .active_o     (ctl_write),
        .idle_o       (idle),
        .busy_o       (ctl_busy),
        .dma_req_o    (dma_req),
        .take_lo_o    (take_lo),
        .take_hi_o    (take_hi),
        .commit_o     (commit)
    );

    fww_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_tmr),
        .run_i  (ctl_busy),
        .done_o (prog_done)
    );

    fww_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .idle_i       (idle),
        .busy_i       (ctl_busy),
        .take_lo_i    (take_lo),
        .take_hi_i    (take_hi),
        .commit_i     (commit),
        .cpu_req_i    (cpu_req),
        .addr_o       (cur_waddr),
        .count_o      (bytes_left),
        .word_o       (word),
        .viol_o       (ctl_viol),
        .count_zero_o (count_zero)
    );

    fww_array #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (commit),
        .waddr_i (cur_waddr),
        .wdata_i (word),
        .busy_i  (ctl_busy),
        .raddr_i (cpu_waddr),
        .ready_o (cpu_ready),
        .rdata_o (cpu_rdata)
    );
endmodule

// File: rtl/fww_checks.sv
module fww_checks
    import fww_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              ctl_write,
    input logic              ctl_busy,
    input logic              ctl_viol,
    input logic [ADDR_W-1:0] cur_waddr,
    input logic              dma_req,
    input logic              cpu_req,
    input logic              cpu_ready
);
    a_r4_no_req_in_program: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |-> !dma_req);

    a_r8_no_req_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_write |-> !dma_req);

    a_r6_busy_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_busy) |-> $past(reg_we && reg_sel == SEL_DATA));

    a_r7_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_busy) |-> cur_waddr == ADDR_W'($past(cur_waddr) + 1'b1));

    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_write && !ctl_busy) |=> $stable(cur_waddr));

    a_r9_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |-> !cpu_ready);

    a_r9_viol_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && cpu_req) |=> ctl_viol);

    a_r11_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_viol && !(reg_we && reg_sel == SEL_CTRL && reg_wdata[CTRL_CLR_BIT]))
        |=> ctl_viol);
endmodule

bind flash_word_writer fww_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ctl_write (ctl_write),
    .ctl_busy  (ctl_busy),
    .ctl_viol  (ctl_viol),
    .cur_waddr (cur_waddr),
    .dma_req   (dma_req),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready)
);

// File: tb/test_flash_word_writer.sv
module test_flash_word_writer;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 14;
    localparam int CNT_W       = 10;
    localparam int PROG_CYCLES = 6;
    localparam int MEM_DEPTH   = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [ADDR_W-1:0] reg_wdata = '0;
    logic              cpu_req = 1'b0;
    logic [ADDR_W-1:0] cpu_waddr = '0;
    logic              ctl_write, ctl_busy, ctl_viol, dma_req, cpu_ready;
    logic [ADDR_W-1:0] cur_waddr;
    logic [CNT_W-1:0]  bytes_left;
    logic [15:0]       cpu_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    logic [7:0] seed = 8'h10;

    flash_word_writer #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PROG_CYCLES(PROG_CYCLES), .MEM_DEPTH(MEM_DEPTH)
    ) i_flash_word_writer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_write(ctl_write), .ctl_busy(ctl_busy), .ctl_viol(ctl_viol),
        .cur_waddr(cur_waddr), .bytes_left(bytes_left), .dma_req(dma_req),
        .cpu_req(cpu_req), .cpu_waddr(cpu_waddr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int         m_mode;      // 0 idle, 1 low byte, 2 high byte, 3 programming
    int         m_left;
    int         m_addr, m_cnt;
    int         m_lo, m_word;
    bit         m_viol;
    logic [15:0] m_mem [MEM_DEPTH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_addr = 0; m_cnt = 0;
            m_lo = 0; m_word = 0; m_viol = 1'b0;
            for (int i = 0; i < MEM_DEPTH; i++) m_mem[i] = 16'hFFFF;
        end else begin
            bit busy, dwr, ctrl;
            busy = (m_mode == 3);
            dwr  = reg_we && reg_sel == 2'd3;
            ctrl = reg_we && reg_sel == 2'd0;
            if (ctrl && reg_wdata[1]) m_viol = 1'b0;
            if (busy && (dwr || cpu_req)) m_viol = 1'b1;
            case (m_mode)
                0: begin
                    if (reg_we && reg_sel == 2'd1) m_addr = int'(reg_wdata);
                    if (reg_we && reg_sel == 2'd2) m_cnt = int'(reg_wdata) % 1024 / 2 * 2;
                    if (ctrl && reg_wdata[0] && m_cnt != 0) m_mode = 1;
                end
                1: if (dwr) begin m_lo = int'(reg_wdata[7:0]); m_cnt--; m_mode = 2; end
                2: if (dwr) begin
                    m_word = int'(reg_wdata[7:0]) * 256 + m_lo;
                    m_cnt--; m_mode = 3; m_left = PROG_CYCLES;
                end
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_addr < MEM_DEPTH) m_mem[m_addr] = 16'(m_word);
                        m_addr = (m_addr + 1) % 16384;
                        m_mode = (m_cnt == 0) ? 0 : 1;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            int exp_rd;
            if (m_mode == 3)                exp_rd = 0;
            else if (cpu_waddr < MEM_DEPTH) exp_rd = int'(m_mem[cpu_waddr]);
            else                            exp_rd = 16'hFFFF;
            chk("R3/R8 ctl_write", int'(ctl_write), int'(m_mode != 0));
            chk("R6 ctl_busy", int'(ctl_busy), int'(m_mode == 3));
            chk("R10/R11 ctl_viol", int'(ctl_viol), int'(m_viol));
            chk("R7/R2 cur_waddr", int'(cur_waddr), m_addr);
            chk("R5/R2 bytes_left", int'(bytes_left), m_cnt);
            chk("R4 dma_req", int'(dma_req), int'(m_mode == 1 || m_mode == 2));
            chk("R9 cpu_ready", int'(cpu_ready), int'(m_mode != 3));
            chk("R12/R9 cpu_rdata", int'(cpu_rdata), exp_rd);
        end
    end

    task automatic quiet();
        reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0; cpu_req = 1'b0;
    endtask

    task automatic idle_cyc();
        @(posedge clk); #1; quiet();
    endtask

    task automatic reg_write(input logic [1:0] sel, input int val);
        @(posedge clk); #1; quiet();
        reg_we = 1'b1; reg_sel = sel; reg_wdata = ADDR_W'(val);
    endtask

    task automatic cpu_read(input int a);
        @(posedge clk); #1; quiet();
        cpu_req = 1'b1; cpu_waddr = ADDR_W'(a);
    endtask

    // mode: 0 plain, 1 CPU pokes while busy, 2 data writes while busy,
    // 3 address/count/start writes while busy, 4 CPU poke plus clear together
    task automatic run_session(input int mode);
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk); #1; quiet();
            if (!ctl_write && c > 0) break;
            if (dma_req) begin
                reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = ADDR_W'(seed); seed = seed + 8'd37;
            end else if (ctl_busy) begin
                case (mode)
                    1: begin cpu_req = 1'b1; cpu_waddr = ADDR_W'(c); end
                    2: begin reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = ADDR_W'(8'hEE); end
                    3: begin reg_we = 1'b1; reg_sel = 2'(c % 3); reg_wdata = 14'h3331; end
                    4: begin cpu_req = 1'b1; reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 14'h2; end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic start_session(input int addr, input int cnt);
        reg_write(2'd1, addr);
        reg_write(2'd2, cnt);
        reg_write(2'd0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 write", int'(ctl_write), 0);
        chk("R1 busy", int'(ctl_busy), 0);
        chk("R1 viol", int'(ctl_viol), 0);
        chk("R1 addr", int'(cur_waddr), 0);
        chk("R1 count", int'(bytes_left), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 ready", int'(cpu_ready), 1);
        chk("R1 erased", int'(cpu_rdata), 16'hFFFF);
        cmp_on = 1'b1;

        // R7 page crossing, R5 byte order
        start_session(14'h01FE, 6);
        run_session(0);
        for (int a = 14'h01FD; a <= 14'h0201; a++) cpu_read(a);

        // R9 stall and violation, R2 odd count rounding
        start_session(14'h0300, 5);
        run_session(1);
        cpu_read(14'h0301);
        reg_write(2'd0, 2);   // R11 clear
        idle_cyc();

        // R10 data writes while programming
        start_session(14'h0100, 4);
        run_session(2);
        cpu_read(14'h0100);
        cpu_read(14'h0101);
        reg_write(2'd0, 2);

        // R3 start with zero count ignored, R10 idle data write ignored
        reg_write(2'd2, 0);
        reg_write(2'd0, 1);
        idle_cyc();
        reg_write(2'd3, 8'h55);
        idle_cyc();
        chk("R3 zero count start", int'(ctl_write), 0);
        chk("R10 idle data no viol", int'(ctl_viol), 0);

        // R2/R3 register writes and restart while busy ignored
        start_session(14'h0040, 4);
        run_session(3);
        cpu_read(14'h0040);
        cpu_read(14'h0041);

        // R11 violation wins over clear in the same cycle
        start_session(14'h0050, 2);
        run_session(4);
        idle_cyc();
        chk("R11 set wins", int'(ctl_viol), 1);
        reg_write(2'd0, 2);
        idle_cyc();

        // R12 out-of-range program dropped, R8 session end
        start_session(14'h05FF, 2);
        run_session(0);
        cpu_read(14'h05FF);
        idle_cyc();
        chk("R8 session ended", int'(ctl_write), 0);
        chk("R12 out of range", int'(cpu_rdata), 16'hFFFF);
        repeat (3) idle_cyc();

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule